// File: doc/BRIEF.md
# Start-Up Delay Sequencer

This block keeps a processor core out of operation after a reset and after a wake-up from a deep sleep. It raises its ready flag only once a start-up delay has passed. A 2-bit delay code, wired like a fuse setting, selects that delay. Every valid code gives a short count of clock cycles. The reset path adds a longer wait counted in millisecond tick pulses. The wake-up path uses only the short count. One code value is reserved. When that value is selected, the block refuses to release the core and raises an error flag instead.

The reset request is asynchronous. While it is high, both outputs are low and the sequence is held at its start. The first rising clock edge with the reset request low is the capture edge (called E0 below). At E0 the block latches the delay code, and later changes on the code pins have no effect on that sequence. A wake-up request taken while the core is ready latches the code again and runs only the short count.

The controller is a five-state machine:
- CAPTURE: latch the code after reset.
- MS_WAIT: count millisecond ticks.
- CLK_WAIT: count clock cycles.
- READY: the core is released.
- FAULT: the reserved code was seen.

Its transitions are:
- CAPTURE→MS_WAIT: code 01 or 10.
- CAPTURE→CLK_WAIT: code 00.
- CAPTURE→FAULT: code 11.
- MS_WAIT→CLK_WAIT: the last tick is counted.
- CLK_WAIT→READY: the cycle count ends.
- READY→CLK_WAIT: a wake-up request with a valid code.
- READY→FAULT: a wake-up request with code 11.
- Any state→CAPTURE: the asynchronous reset request.

Top module: `startup_seq`

## Requirements
- R1: While `rst_req` is high, `core_ready` and `code_err` are both 0, and asserting `rst_req` drops `core_ready` at once, with no clock edge needed.
- R2: With code 00 (no extra wait) latched at E0, `core_ready` goes to 1 at the 6th rising edge after E0 and stays 1.
- R3: With code 01 (short wait), the block counts `ms_tick` pulses sampled high at edges after E0. `core_ready` goes to 1 at the 6th edge after the edge that samples the 4th pulse.
- R4: With code 10 (long wait), `core_ready` goes to 1 at the 6th edge after the edge that samples the 64th `ms_tick` pulse.
- R5: With code 11 (reserved) latched, `code_err` goes to 1 at that edge and `core_ready` stays 0. This holds until `rst_req` is asserted.
- R6: `wake_req` sampled high at edge W while `core_ready` is 1 drops `core_ready` after W. For a valid code, `core_ready` returns to 1 at edge W+6, with no millisecond wait.
- R7: `wake_req` has no effect unless `core_ready` is 1. It does not change the timing of a running sequence and does not clear `code_err`.
- R8: The code is sampled only at E0 and at an accepted wake-up edge. Changes to `dly_code` at other times do not alter the running sequence.
- R9: A reset request during any phase restarts the sequence. Ticks counted before the reset do not count toward the next sequence.
- R10: A wake-up taken while `dly_code` is 11 leads to FAULT: `code_err` is 1 after W and `core_ready` stays 0.
- R11: `ms_tick` pulses outside the millisecond wait (at E0, during the cycle count, or while ready) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_req | input | 1 | Asynchronous reset request, active high |
| wake_req | input | 1 | Wake-up from sleep request, sampled at rising edges |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| dly_code | input | 2 | Start-up delay code: 00 none, 01 short, 10 long, 11 reserved |
| core_ready | output | 1 | Core released from start-up hold |
| code_err | output | 1 | Reserved code latched |

## Verification
The hardest case to reach is a restart in the middle of the millisecond wait. A design that fails to clear its tick count looks correct from the ports unless the second sequence is timed exactly. To expose it, the bench drives a short-wait sequence for three ticks and then asserts reset. It then restarts and predicts ready exactly six edges after the fourth new tick. A stale count would release the core several ticks early. The scoreboard would then see the rise at the wrong cycle. Similarly, code changes and stray wake-up pulses are injected mid-sequence so that any early release shows up as a timing mismatch.

// File: rtl/sud_pkg.sv
`timescale 1ns/1ps
package sud_pkg;

    typedef enum logic [2:0] {
        ST_CAPTURE  = 3'd0,
        ST_MS_WAIT  = 3'd1,
        ST_CLK_WAIT = 3'd2,
        ST_READY    = 3'd3,
        ST_FAULT    = 3'd4
    } sud_state_e;

    typedef enum logic [1:0] {
        CODE_NONE  = 2'b00,
        CODE_SHORT = 2'b01,
        CODE_LONG  = 2'b10,
        CODE_RSVD  = 2'b11
    } sud_code_e;

endpackage

// File: rtl/sud_decode.sv
`timescale 1ns/1ps
module sud_decode
    import sud_pkg::*;
#(
    parameter int MS_SHORT = 4,
    parameter int MS_LONG  = 64,
    parameter int MW       = 7
) (
    input  logic [1:0]    code,
    output logic [MW-1:0] ms_last,
    output logic          ms_needed,
    output logic          code_ok
);

    sud_code_e code_e;

    always_comb begin
        code_e    = sud_code_e'(code);
        ms_last   = '0;
        ms_needed = 1'b0;
        code_ok   = 1'b1;
        unique case (code_e)
            CODE_NONE: begin
                ms_needed = 1'b0;
            end
            CODE_SHORT: begin
                ms_needed = 1'b1;
                ms_last   = MW'(MS_SHORT - 1);
            end
            CODE_LONG: begin
                ms_needed = 1'b1;
                ms_last   = MW'(MS_LONG - 1);
            end
            CODE_RSVD: begin
                code_ok   = 1'b0;
            end
            default: begin
                code_ok   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sud_counter.sv
`timescale 1ns/1ps
module sud_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] last_val,
    output logic         at_last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = run && step && (cnt_q == last_val);

endmodule

// File: rtl/sud_fsm.sv
`timescale 1ns/1ps
module sud_fsm
    import sud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_req,
    input  logic       wake_req,
    input  logic [1:0] code_in,
    input  logic       dec_ok,
    input  logic       dec_ms,
    input  logic       ms_done,
    input  logic       clk_done,
    output logic [1:0] lat_code,
    output logic       sample_now,
    output logic       run_ms,
    output logic       run_clk,
    output logic       core_ready,
    output logic       code_err
);

    sud_state_e state_q;
    sud_state_e state_d;

    // state register
    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) begin
            state_q <= ST_CAPTURE;
        end else begin
            state_q <= state_d;
        end
    end

    // code latch, loaded only at capture or accepted wake-up
    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) begin
            lat_code <= 2'b00;
        end else if (sample_now) begin
            lat_code <= code_in;
        end
    end

    assign sample_now = (state_q == ST_CAPTURE) ||
                        ((state_q == ST_READY) && wake_req);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CAPTURE: begin
                if (!dec_ok) begin
                    state_d = ST_FAULT;
                end else if (dec_ms) begin
                    state_d = ST_MS_WAIT;
                end else begin
                    state_d = ST_CLK_WAIT;
                end
            end
            ST_MS_WAIT: begin
                if (ms_done) begin
                    state_d = ST_CLK_WAIT;
                end
            end
            ST_CLK_WAIT: begin
                if (clk_done) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                if (wake_req) begin
                    state_d = dec_ok ? ST_CLK_WAIT : ST_FAULT;
                end
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: begin
                state_d = ST_CAPTURE;
            end
        endcase
    end

    // outputs
    always_comb begin
        run_ms     = (state_q == ST_MS_WAIT);
        run_clk    = (state_q == ST_CLK_WAIT);
        core_ready = (state_q == ST_READY) && !rst_req;
        code_err   = (state_q == ST_FAULT) && !rst_req;
    end

endmodule

// File: rtl/startup_seq.sv
`timescale 1ns/1ps
module startup_seq
    import sud_pkg::*;
#(
    parameter int CLK_CYCLES = 6,
    parameter int MS_SHORT   = 4,
    parameter int MS_LONG    = 64
) (
    input  logic       clk,
    input  logic       rst_req,
    input  logic       wake_req,
    input  logic       ms_tick,
    input  logic [1:0] dly_code,
    output logic       core_ready,
    output logic       code_err
);

    localparam int CW = $clog2(CLK_CYCLES + 1);
    localparam int MW = $clog2(MS_LONG + 1);

    logic [1:0]    lat_code;
    logic [1:0]    dec_code;
    logic          sample_now;
    logic [MW-1:0] ms_last;
    logic          dec_ms;
    logic          dec_ok;
    logic          run_ms;
    logic          run_clk;
    logic          ms_done;
    logic          clk_done;

    assign dec_code = sample_now ? dly_code : lat_code;

    sud_decode #(
        .MS_SHORT (MS_SHORT),
        .MS_LONG  (MS_LONG),
        .MW       (MW)
    ) u_dec (
        .code      (dec_code),
        .ms_last   (ms_last),
        .ms_needed (dec_ms),
        .code_ok   (dec_ok)
    );

    sud_counter #(.W(MW)) u_ms_cnt (
        .clk      (clk),
        .rst      (rst_req),
        .run      (run_ms),
        .step     (ms_tick),
        .last_val (ms_last),
        .at_last  (ms_done)
    );

    sud_counter #(.W(CW)) u_clk_cnt (
        .clk      (clk),
        .rst      (rst_req),
        .run      (run_clk),
        .step     (1'b1),
        .last_val (CW'(CLK_CYCLES - 1)),
        .at_last  (clk_done)
    );

    sud_fsm u_fsm (
        .clk        (clk),
        .rst_req    (rst_req),
        .wake_req   (wake_req),
        .code_in    (dly_code),
        .dec_ok     (dec_ok),
        .dec_ms     (dec_ms),
        .ms_done    (ms_done),
        .clk_done   (clk_done),
        .lat_code   (lat_code),
        .sample_now (sample_now),
        .run_ms     (run_ms),
        .run_clk    (run_clk),
        .core_ready (core_ready),
        .code_err   (code_err)
    );

endmodule

// File: rtl/sud_checker.sv
`timescale 1ns/1ps
module sud_checker #(
    parameter int CLK_CYCLES = 6
) (
    input logic clk,
    input logic rst_req,
    input logic wake_req,
    input logic core_ready,
    input logic code_err
);

    localparam int LW = $clog2(CLK_CYCLES + 2);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) begin
            low_run <= '0;
        end else if (core_ready) begin
            low_run <= '0;
        end else if (low_run != LW'(CLK_CYCLES + 1)) begin
            low_run <= low_run + 1'b1;
        end
    end

    p_ready_gap_r2: assert property (@(posedge clk) disable iff (rst_req)
        $rose(core_ready) |-> (low_run >= LW'(CLK_CYCLES)));

    p_fault_exclusive_r5: assert property (@(posedge clk) disable iff (rst_req)
        code_err |-> !core_ready);

    p_fault_sticky_r5: assert property (@(posedge clk) disable iff (rst_req)
        code_err |=> code_err);

    p_wake_drop_r6: assert property (@(posedge clk) disable iff (rst_req)
        (core_ready && wake_req) |=> !core_ready);

    p_ready_hold_r7: assert property (@(posedge clk) disable iff (rst_req)
        (core_ready && !wake_req) |=> core_ready);

endmodule

bind startup_seq sud_checker #(.CLK_CYCLES(CLK_CYCLES)) u_sud_chk (
    .clk        (clk),
    .rst_req    (rst_req),
    .wake_req   (wake_req),
    .core_ready (core_ready),
    .code_err   (code_err)
);

// File: tb/startup_seq_test.sv
`timescale 1ns/1ps
module startup_seq_test;

    logic       clk = 1'b0;
    logic       rst_req;
    logic       wake_req;
    logic       ms_tick;
    logic [1:0] dly_code;
    logic       core_ready;
    logic       code_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    typedef struct {
        bit    is_err;
        int    at;
        string req;
    } exp_t;

    exp_t sb_q[$];
    logic prev_rdy = 1'b0;
    logic prev_err = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    startup_seq uut (
        .clk        (clk),
        .rst_req    (rst_req),
        .wake_req   (wake_req),
        .ms_tick    (ms_tick),
        .dly_code   (dly_code),
        .core_ready (core_ready),
        .code_err   (code_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic push(input bit is_err, input int at, input string req);
        exp_t e;
        e.is_err = is_err;
        e.at     = at;
        e.req    = req;
        sb_q.push_back(e);
    endtask

    task automatic observe(input bit is_err);
        exp_t e;
        if (sb_q.size() == 0) begin
            check(1'b0, is_err ? "R5" : "R2", "unexpected rise at cycle", cyc, -1);
        end else begin
            e = sb_q.pop_front();
            check(e.is_err == is_err, e.req, "event kind", int'(is_err), int'(e.is_err));
            check(e.at == cyc, e.req, "event cycle", cyc, e.at);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (core_ready === 1'b1 && prev_rdy !== 1'b1) observe(1'b0);
        if (code_err === 1'b1 && prev_err !== 1'b1) observe(1'b1);
        prev_rdy = core_ready;
        prev_err = code_err;
    end

    task automatic drain(input string req);
        int t = 0;
        while (sb_q.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(sb_q.size() == 0, req, "pending expected events", sb_q.size(), 0);
        @(negedge clk);
    endtask

    task automatic release_rst(input logic [1:0] code, output int e0);
        dly_code = code;
        rst_req  = 1'b0;
        e0 = cyc + 1;
        @(negedge clk);
    endtask

    task automatic send_ticks(input int n, input int gap, output int last);
        last = 0;
        for (int i = 0; i < n; i++) begin
            repeat (gap - 1) @(negedge clk);
            ms_tick = 1'b1;
            last = cyc + 1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic do_wake(output int w);
        wake_req = 1'b1;
        w = cyc + 1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int e0;
        int last;
        int w;
        rst_req  = 1'b1;
        wake_req = 1'b0;
        ms_tick  = 1'b0;
        dly_code = 2'b00;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(core_ready == 1'b0, "R1", "ready in reset", core_ready, 0);
        check(code_err == 1'b0, "R1", "err in reset", code_err, 0);

        // R2: code 00, ready six edges after E0
        release_rst(2'b00, e0);
        push(1'b0, e0 + 6, "R2");
        drain("R2");
        // R11: ticks while ready do nothing
        send_ticks(3, 1, last);
        check(core_ready == 1'b1, "R11", "ready after idle ticks", core_ready, 1);

        // R6: wake from ready, R11 ticks during cycle count ignored
        do_wake(w);
        check(core_ready == 1'b0, "R6", "ready right after wake", core_ready, 0);
        push(1'b0, w + 6, "R6");
        send_ticks(2, 1, last);
        drain("R6");

        // R3: code 01 with a stray wake in the tick wait (R7)
        rst_req = 1'b1;
        @(negedge clk);
        release_rst(2'b01, e0);
        send_ticks(2, 3, last);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        send_ticks(2, 3, last);
        push(1'b0, last + 6, "R3");
        drain("R3");

        // R4: code 10, code pins changed after capture (R8)
        rst_req = 1'b1;
        @(negedge clk);
        release_rst(2'b10, e0);
        dly_code = 2'b00;
        send_ticks(64, 1, last);
        push(1'b0, last + 6, "R4");
        drain("R4");

        // R6 / R8: wake runs only the cycle count, code change ignored
        dly_code = 2'b01;
        do_wake(w);
        push(1'b0, w + 6, "R8");
        dly_code = 2'b11;
        drain("R8");
        check(code_err == 1'b0, "R8", "err after ignored code change", code_err, 0);

        // R1 / R9: reset drops ready at once
        rst_req = 1'b1;
        #1;
        check(core_ready == 1'b0, "R9", "ready right after reset request", core_ready, 0);
        @(negedge clk);

        // R9: restart in the middle of the tick wait
        release_rst(2'b01, e0);
        send_ticks(3, 2, last);
        rst_req = 1'b1;
        repeat (2) @(negedge clk);
        release_rst(2'b01, e0);
        send_ticks(4, 2, last);
        push(1'b0, last + 6, "R9");
        drain("R9");

        // R5: reserved code, then stray wakes and ticks (R7)
        rst_req = 1'b1;
        @(negedge clk);
        release_rst(2'b11, e0);
        push(1'b1, e0, "R5");
        drain("R5");
        dly_code = 2'b00;
        send_ticks(5, 2, last);
        do_wake(w);
        repeat (10) @(negedge clk);
        check(core_ready == 1'b0, "R5", "ready held in fault", core_ready, 0);
        check(code_err == 1'b1, "R7", "err after wake in fault", code_err, 1);
        rst_req = 1'b1;
        #1;
        check(code_err == 1'b0, "R1", "err cleared by reset", code_err, 0);
        @(negedge clk);

        // R10: wake with reserved code on the pins
        release_rst(2'b00, e0);
        push(1'b0, e0 + 6, "R2");
        drain("R2");
        dly_code = 2'b11;
        do_wake(w);
        push(1'b1, w, "R10");
        drain("R10");
        check(core_ready == 1'b0, "R10", "ready after bad wake", core_ready, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule